// File: doc/BRIEF.md
# Framebuffer Scan-Out Display Controller

This block shows a 640x480 true-color picture held in memory on a TFT or VGA panel. It runs the line and frame timing itself. For every visible pixel it computes the address of one 32-bit memory word and issues a single-word read on a plain request/valid port. It then presents the colour in that word on three 8-bit outputs, together with active-low sync pulses and a data-enable strobe.

Software controls the block through two 32-bit registers. The first gives the frame base in memory, and only its upper 11 bits are stored. The second holds a display-on bit and a bit that turns the picture upside down and mirrors it.

Memory answers a fixed number of cycles after each request. Sync and data-enable are delayed by the same amount so that timing and colour leave the block together. A new base or rotate setting takes effect only at the first blanking line after the active area, so one frame never mixes two settings.

Top module: `fb_scanout`

## Requirements
- R1: Register index 0 is the frame base. Only write-data bits 31:21 are stored, and readback shows those bits with bits 20:0 as zero. Register index 1 is control: bit 0 is display-on, bit 1 is rotate, and readback shows those two bits with all other bits zero. Both registers reset to zero.
- R2: Horizontal sync is low for HSY clocks in every HTOT-clock line, starting HACT+HFP clocks into the line. Vertical sync is low for VSY whole lines in every VTOT-line frame, starting after VACT+VFP lines. Both syncs run whether or not the display is on.
- R3: With display-on set, the block issues exactly one read request per visible pixel (HACT*VACT per frame) and issues none during blanking.
- R4: Without rotate, the request for pixel (x, y) is at address {base[31:21], 21'b0} + (y*STRIDE + x)*4. Pixels are requested in raster order, left to right and top to bottom.
- R5: With rotate, the k-th request of a frame fetches pixel (HACT-1-x, VACT-1-y), where (x, y) is the k-th raster position.
- R6: The colour of the word returned for a request appears on the outputs LAT+1 clocks after the request, with data-enable high. Red is word bits 23:16, green is bits 15:8 and blue is bits 7:0. Bits 31:24 have no effect.
- R7: With display-on clear, no requests are issued, data-enable stays low and the colour outputs stay at zero.
- R8: A write to the base register or to the rotate bit changes no request in the frame being scanned. The new value applies from the frame that follows the next vertical blanking.
- R9: Whenever data-enable is low, all three colour outputs are zero.
- R10: During reset, data-enable, the colour outputs and the read request are low, and both syncs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Register write strobe |
| regIdx | input | 1 | Register select: 0 base, 1 control |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Readback of the selected register |
| memReq | output | 1 | Single-word read request |
| memAddr | output | 32 | Byte address of the requested word |
| memRdData | input | 32 | Returned pixel word |
| memValid | input | 1 | Returned word is valid this cycle |
| pixR | output | 8 | Red level |
| pixG | output | 8 | Green level |
| pixB | output | 8 | Blue level |
| pixDe | output | 1 | Data enable, high on visible pixels |
| hSyncN | output | 1 | Horizontal sync, active low |
| vSyncN | output | 1 | Vertical sync, active low |

## Verification
The assertions assume that the memory raises memValid exactly LAT cycles after every request and never makes the block wait. The bench memory model is a plain LAT-stage delay line, so this always holds. The bench reconstructs the expected configuration of each frame at the output vertical-sync fall. It therefore never writes a register between the start of vertical blanking and that fall. Its writes land either just after the fall or in the middle of the active area.

// File: rtl/fb_scan_pkg.sv
package fb_scan_pkg;
  // Strobes handed from the timing control to the pixel datapath
  typedef struct packed {
    logic active;      // current position is a visible pixel
    logic frameLatch;  // first clock of the first blanking line
    logic hSyncN;
    logic vSyncN;
  } scan_strobe_t;
endpackage

// File: rtl/fb_scan_timing.sv
module fb_scan_timing
  import fb_scan_pkg::*;
#(
  parameter int HACT = 640,
  parameter int HFP  = 16,
  parameter int HSY  = 96,
  parameter int HBP  = 48,
  parameter int VACT = 480,
  parameter int VFP  = 10,
  parameter int VSY  = 2,
  parameter int VBP  = 33,
  localparam int HTOT = HACT + HFP + HSY + HBP,
  localparam int VTOT = VACT + VFP + VSY + VBP,
  localparam int XW   = $clog2(HTOT),
  localparam int YW   = $clog2(VTOT)
) (
  input  logic          clk,
  input  logic          rstN,
  output logic [XW-1:0] xPos,
  output logic [YW-1:0] yPos,
  output scan_strobe_t  stb
);
  localparam logic [XW-1:0] H_LAST = XW'(HTOT - 1);
  localparam logic [XW-1:0] H_ACT  = XW'(HACT);
  localparam logic [XW-1:0] HS_ON  = XW'(HACT + HFP);
  localparam logic [XW-1:0] HS_OFF = XW'(HACT + HFP + HSY);
  localparam logic [YW-1:0] V_LAST = YW'(VTOT - 1);
  localparam logic [YW-1:0] V_ACT  = YW'(VACT);
  localparam logic [YW-1:0] VS_ON  = YW'(VACT + VFP);
  localparam logic [YW-1:0] VS_OFF = YW'(VACT + VFP + VSY);

  logic [XW-1:0] hCnt;
  logic [YW-1:0] vCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hCnt <= '0;
      vCnt <= '0;
    end else if (hCnt == H_LAST) begin
      hCnt <= '0;
      vCnt <= (vCnt == V_LAST) ? '0 : vCnt + 1'b1;
    end else begin
      hCnt <= hCnt + 1'b1;
    end
  end

  assign xPos           = hCnt;
  assign yPos           = vCnt;
  assign stb.active     = (hCnt < H_ACT) && (vCnt < V_ACT);
  assign stb.frameLatch = (hCnt == '0) && (vCnt == V_ACT);
  assign stb.hSyncN     = !((hCnt >= HS_ON) && (hCnt < HS_OFF));
  assign stb.vSyncN     = !((vCnt >= VS_ON) && (vCnt < VS_OFF));

  // R2: line counter wraps into the next line, frame wraps to line 0
  p_line_wrap_r2: assert property (@(posedge clk) disable iff (!rstN)
    (hCnt == H_LAST) |=> (hCnt == '0) &&
      (vCnt == (($past(vCnt) == V_LAST) ? '0 : $past(vCnt) + 1'b1)));

  // R2: vertical sync only moves on a line boundary
  p_vsync_edge_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(stb.vSyncN) |-> (hCnt == '0));
endmodule

// File: rtl/fb_scan_datapath.sv
module fb_scan_datapath
  import fb_scan_pkg::*;
#(
  parameter int HACT     = 640,
  parameter int VACT     = 480,
  parameter int XW       = 10,
  parameter int YW       = 10,
  parameter int STRIDE   = 1024,
  parameter int AW       = 32,
  parameter int BASE_LSB = 21,
  parameter int LAT      = 2,
  localparam int SW      = $clog2(STRIDE),
  localparam int OW      = BASE_LSB - 2,
  localparam int BW      = AW - BASE_LSB
) (
  input  logic          clk,
  input  logic          rstN,
  input  scan_strobe_t  stb,
  input  logic [XW-1:0] xPos,
  input  logic [YW-1:0] yPos,
  input  logic          regWrEn,
  input  logic          regIdx,
  input  logic [AW-1:0] regWrData,
  output logic [AW-1:0] regRdData,
  output logic          memReq,
  output logic [AW-1:0] memAddr,
  input  logic [31:0]   memRdData,
  input  logic          memValid,
  output logic [7:0]    pixR,
  output logic [7:0]    pixG,
  output logic [7:0]    pixB,
  output logic          pixDe,
  output logic          hSyncN,
  output logic          vSyncN
);
  localparam logic [XW-1:0] X_MAX = XW'(HACT - 1);
  localparam logic [YW-1:0] Y_MAX = YW'(VACT - 1);
  localparam logic [BASE_LSB-1:0] FRAME_END = BASE_LSB'(VACT * STRIDE * 4 - 1);

  // programmed registers and the copies used by the frame being shown
  logic [BW-1:0] baseReg, actBase;
  logic          ctrlEn, ctrlRot, actRot;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseReg <= '0;
      ctrlEn  <= 1'b0;
      ctrlRot <= 1'b0;
    end else if (regWrEn) begin
      if (regIdx) begin
        ctrlEn  <= regWrData[0];
        ctrlRot <= regWrData[1];
      end else begin
        baseReg <= regWrData[AW-1:BASE_LSB];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actBase <= '0;
      actRot  <= 1'b0;
    end else if (stb.frameLatch) begin
      actBase <= baseReg;
      actRot  <= ctrlRot;
    end
  end

  assign regRdData = regIdx ? {{(AW-2){1'b0}}, ctrlRot, ctrlEn}
                            : {baseReg, {BASE_LSB{1'b0}}};

  // fetch address
  logic [XW-1:0] xEff;
  logic [YW-1:0] yEff;
  logic [OW-1:0] wordOff;

  assign xEff    = actRot ? (X_MAX - xPos) : xPos;
  assign yEff    = actRot ? (Y_MAX - yPos) : yPos;
  assign wordOff = OW'({yEff, {SW{1'b0}}}) + OW'(xEff);
  assign memReq  = stb.active && ctrlEn;
  assign memAddr = {actBase, wordOff, 2'b00};

  // delay {de, hsync, vsync} by the memory latency
  logic [2:0] dly [LAT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < LAT; i++) dly[i] <= 3'b011;
    end else begin
      dly[0] <= {memReq, stb.hSyncN, stb.vSyncN};
      for (int i = 1; i < LAT; i++) dly[i] <= dly[i-1];
    end
  end

  logic deTap;
  assign deTap = dly[LAT-1][2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pixDe  <= 1'b0;
      pixR   <= '0;
      pixG   <= '0;
      pixB   <= '0;
      hSyncN <= 1'b1;
      vSyncN <= 1'b1;
    end else begin
      pixDe  <= deTap;
      hSyncN <= dly[LAT-1][1];
      vSyncN <= dly[LAT-1][0];
      if (deTap && memValid) begin
        pixR <= memRdData[23:16];
        pixG <= memRdData[15:8];
        pixB <= memRdData[7:0];
      end else begin
        pixR <= '0;
        pixG <= '0;
        pixB <= '0;
      end
    end
  end

  logic unusedBits;
  assign unusedBits = ^{memRdData[31:24], regWrData[BASE_LSB-1:2]};

  // R8: shown configuration moves only on the frame latch strobe
  p_cfg_stable_r8: assert property (@(posedge clk) disable iff (!rstN)
    !stb.frameLatch |=> $stable(actBase) && $stable(actRot));

  // R6: memory must answer LAT cycles after each request
  p_valid_aligned_r6: assert property (@(posedge clk) disable iff (!rstN)
    deTap |-> memValid);

  // R6: a shown pixel always follows a returned word
  p_de_has_data_r6: assert property (@(posedge clk) disable iff (!rstN)
    pixDe |-> $past(memValid));

  // R3: requests stay inside the frame region
  p_req_in_frame_r3: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (memAddr[BASE_LSB-1:0] <= FRAME_END));
endmodule

// File: rtl/fb_scanout.sv
module fb_scanout
  import fb_scan_pkg::*;
#(
  parameter int HACT   = 640,
  parameter int HFP    = 16,
  parameter int HSY    = 96,
  parameter int HBP    = 48,
  parameter int VACT   = 480,
  parameter int VFP    = 10,
  parameter int VSY    = 2,
  parameter int VBP    = 33,
  parameter int STRIDE = 1024,
  parameter int LAT    = 2,
  localparam int XW    = $clog2(HACT + HFP + HSY + HBP),
  localparam int YW    = $clog2(VACT + VFP + VSY + VBP)
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic        regIdx,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic        memReq,
  output logic [31:0] memAddr,
  input  logic [31:0] memRdData,
  input  logic        memValid,
  output logic [7:0]  pixR,
  output logic [7:0]  pixG,
  output logic [7:0]  pixB,
  output logic        pixDe,
  output logic        hSyncN,
  output logic        vSyncN
);
  scan_strobe_t  stb;
  logic [XW-1:0] xPos;
  logic [YW-1:0] yPos;

  fb_scan_timing #(
    .HACT(HACT), .HFP(HFP), .HSY(HSY), .HBP(HBP),
    .VACT(VACT), .VFP(VFP), .VSY(VSY), .VBP(VBP)
  ) uTiming (
    .clk(clk), .rstN(rstN), .xPos(xPos), .yPos(yPos), .stb(stb)
  );

  fb_scan_datapath #(
    .HACT(HACT), .VACT(VACT), .XW(XW), .YW(YW), .STRIDE(STRIDE),
    .AW(32), .BASE_LSB(21), .LAT(LAT)
  ) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .xPos(xPos), .yPos(yPos),
    .regWrEn(regWrEn), .regIdx(regIdx), .regWrData(regWrData),
    .regRdData(regRdData), .memReq(memReq), .memAddr(memAddr),
    .memRdData(memRdData), .memValid(memValid),
    .pixR(pixR), .pixG(pixG), .pixB(pixB), .pixDe(pixDe),
    .hSyncN(hSyncN), .vSyncN(vSyncN)
  );
endmodule

// File: tb/sim_fb_scanout.sv
module sim_fb_scanout;
  localparam int HACT = 8, HFP = 2, HSY = 3, HBP = 3;
  localparam int VACT = 4, VFP = 1, VSY = 2, VBP = 1;
  localparam int HTOT = HACT + HFP + HSY + HBP;
  localparam int VTOT = VACT + VFP + VSY + VBP;
  localparam int STRIDE = 16, LAT = 3;
  localparam int NPIX = HACT * VACT;
  localparam int NVEC = 5;
  // each vector: {base write value, control bits [1:0]}
  localparam logic [33:0] VEC [NVEC] = '{
    {32'h0020_0000, 2'b01},
    {32'hFFE0_1234, 2'b11},
    {32'h1234_5678, 2'b00},
    {32'h8005_0000, 2'b10},
    {32'h4000_0000, 2'b01}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regIdx = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData, memAddr, memRdData;
  logic        memReq, memValid, pixDe, hSyncN, vSyncN;
  logic [7:0]  pixR, pixG, pixB;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fb_scanout #(.HACT(HACT), .HFP(HFP), .HSY(HSY), .HBP(HBP),
               .VACT(VACT), .VFP(VFP), .VSY(VSY), .VBP(VBP),
               .STRIDE(STRIDE), .LAT(LAT)) u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regIdx(regIdx),
    .regWrData(regWrData), .regRdData(regRdData), .memReq(memReq),
    .memAddr(memAddr), .memRdData(memRdData), .memValid(memValid),
    .pixR(pixR), .pixG(pixG), .pixB(pixB), .pixDe(pixDe),
    .hSyncN(hSyncN), .vSyncN(vSyncN));

  function automatic logic [31:0] memWord(input logic [31:0] a);
    return {8'hEE, a[25:18], a[17:10] ^ 8'h3C, a[9:2]};
  endfunction

  function automatic logic [31:0] expAddr(input int idx, input logic [31:0] b,
                                          input logic r);
    int x = idx % HACT;
    int y = idx / HACT;
    if (r) begin
      x = HACT - 1 - x;
      y = VACT - 1 - y;
    end
    return {b[31:21], 21'd0} + 32'((y * STRIDE + x) * 4);
  endfunction

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // memory with a fixed latency of LAT cycles
  logic [LAT-1:0] mV;
  logic [31:0]    mA [LAT];
  always @(posedge clk or negedge rstN) begin
    if (!rstN) mV <= '0;
    else begin
      mV    <= {mV[LAT-2:0], memReq};
      mA[0] <= memAddr;
      for (int i = 1; i < LAT; i++) mA[i] <= mA[i-1];
    end
  end
  assign memValid  = mV[LAT-1];
  assign memRdData = mV[LAT-1] ? memWord(mA[LAT-1]) : 32'hDEAD_BEEF;

  // configuration as last written, and as used by the current frame
  logic [31:0] pendBase = '0;
  logic [1:0]  pendCtrl = '0;
  logic [31:0] curBase = '0;
  logic        curRot = 1'b0;
  bit          frameEn = 1'b0;
  bit          firstFall = 1'b1;
  int reqIdx = 0, deIdx = 0, blankBad = 0;
  int hsFalls = 0, hsLow = 0, vsLow = 0;
  logic prevHs = 1'b1, prevVs = 1'b1;

  always @(negedge clk) begin
    if (rstN) begin
      if (prevVs && !vSyncN) begin
        if (!firstFall) begin
          chk(hsFalls == VTOT, frameEn ? "R2 hsync per frame" : "R2/R7 hsync per frame",
              32'(hsFalls), 32'(VTOT));
          chk(hsLow == VTOT * HSY, "R2 hsync width", 32'(hsLow), 32'(VTOT * HSY));
        end
        chk(reqIdx == (frameEn ? NPIX : 0), frameEn ? "R3 request count" : "R7 no requests",
            32'(reqIdx), 32'(frameEn ? NPIX : 0));
        chk(deIdx == (frameEn ? NPIX : 0), frameEn ? "R6 de count" : "R7 de low",
            32'(deIdx), 32'(frameEn ? NPIX : 0));
        chk(blankBad == 0, "R9 colour zero when de low", 32'(blankBad), 32'd0);
        firstFall = 1'b0;
        reqIdx = 0; deIdx = 0; blankBad = 0; hsFalls = 0; hsLow = 0;
        curBase = pendBase;
        curRot  = pendCtrl[1];
      end
      if (!prevVs && vSyncN) begin
        chk(vsLow == VSY * HTOT, "R2 vsync width", 32'(vsLow), 32'(VSY * HTOT));
        vsLow = 0;
        frameEn = pendCtrl[0];
      end
      if (memReq) begin
        chk(memAddr == expAddr(reqIdx, curBase, curRot), curRot ? "R5 rotated address" : "R4 address",
            memAddr, expAddr(reqIdx, curBase, curRot));
        reqIdx++;
      end
      if (pixDe) begin
        chk({pixR, pixG, pixB} == memWord(expAddr(deIdx, curBase, curRot))[23:0],
            "R6 pixel colour", {8'd0, pixR, pixG, pixB},
            {8'd0, memWord(expAddr(deIdx, curBase, curRot))[23:0]});
        deIdx++;
      end else if ({pixR, pixG, pixB} != 24'd0) begin
        blankBad++;
      end
      if (prevHs && !hSyncN) hsFalls++;
      if (!hSyncN) hsLow++;
      if (!vSyncN) vsLow++;
      prevHs = hSyncN;
      prevVs = vSyncN;
    end
  end

  task automatic wr(input logic idx, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regIdx = idx; regWrData = d;
    if (idx) pendCtrl = d[1:0];
    else pendBase = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdchk(input logic [31:0] b, input logic [1:0] c);
    regIdx = 1'b0; #1;
    chk(regRdData == {b[31:21], 21'd0}, "R1 base readback", regRdData, {b[31:21], 21'd0});
    regIdx = 1'b1; #1;
    chk(regRdData == {30'd0, c}, "R1 control readback", regRdData, {30'd0, c});
  endtask

  task automatic waitVsFall();
    @(negedge vSyncN);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int hits;
    // R10: state held in reset
    repeat (3) @(negedge clk);
    chk(!pixDe && !memReq, "R10 de and request low", {30'd0, pixDe, memReq}, 32'd0);
    chk({pixR, pixG, pixB} == 24'd0, "R10 colour zero", {8'd0, pixR, pixG, pixB}, 32'd0);
    chk(hSyncN && vSyncN, "R10 syncs high", {30'd0, hSyncN, vSyncN}, 32'd3);
    rdchk(32'd0, 2'b00);
    rstN = 1'b1;
    waitVsFall();

    // vector table: each setting is fully checked one frame after it latches
    for (int v = 0; v < NVEC; v++) begin
      wr(1'b0, VEC[v][33:2]);
      wr(1'b1, {30'd0, VEC[v][1:0]});
      rdchk(VEC[v][33:2], VEC[v][1:0]);
      waitVsFall();
      waitVsFall();
    end

    // R8: change base and rotate in the middle of the active area
    waitVsFall();
    while (reqIdx < NPIX / 2) @(negedge clk);
    wr(1'b0, 32'h6020_0000);
    wr(1'b1, 32'h0000_0003);
    hits = 0;
    while (vSyncN) begin
      @(negedge clk);
      if (memReq && memAddr[31:21] == 11'h301) hits++;
    end
    chk(hits == 0, "R8 no new base within the frame", 32'(hits), 32'd0);
    @(negedge clk);
    waitVsFall();
    waitVsFall();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule